// File: doc/BRIEF.md
# Row-Pipelined Array Execution Controller

This block sequences operations through a configurable array whose rows each act as one stage of a custom pipeline. The processor presents an operation specifier, two or four 32-bit source values and two destination register indices. The controller reads the latency of that operation from a small table that is loaded along with the array configuration. It places the operation in the first row and then moves it forward by one row on every clock. While a row holds an operation, that row's execute enable is high. When the operation reaches the last row of its latency, the two results go out on a write-back port together with their destination indices.

Several operations can be in the rows at the same time, one per row. Results must leave in the order they were issued. An operation with a short latency may therefore not overtake one with a longer latency that was issued before it. The issue port signals not-ready in that case. Rows are modelled as registers. Each row evaluation adds one to the first result lane, so the number of evaluations can be seen in the output data. The content of the array cells is out of scope.

Top module: `rowpipe_exec_ctrl`

## Requirements
- R1: During and right after reset, `row_en` is all zero, `wb_valid` is low and `iss_ready` is high.
- R2: Every latency table entry resets to 1. A write stores `cfg_lat` clamped to the range 1..NUM_ROWS (0 becomes 1, and values above NUM_ROWS become NUM_ROWS).
- R3: An issue accepted in cycle c (`iss_valid` and `iss_ready` both high) drives `row_en[k]` high in cycle c+1+k, for k from 0 to L-1, where L is the table latency of its specifier.
- R4: An operation of latency L receives exactly L row enables. `wb_valid` is high for exactly one cycle, in cycle c+L+1.
- R5: Narrow form (`iss_wide`=0): `wb_data0` = src_a+src_b+L (mod 2^32) and `wb_data1` = src_a^src_b. `iss_src_c` and `iss_src_d` have no effect.
- R6: Wide form (`iss_wide`=1): `wb_data0` = src_a+src_b+src_c+src_d+L and `wb_data1` = src_a^src_b^src_c^src_d.
- R7: `wb_dst0` and `wb_dst1` carry the destination indices given with the issue of the result being written back.
- R8: Results are written back in issue order, at most one per cycle. `iss_ready` is low exactly when the presented operation would write back no later than the latest operation already accepted.
- R9: Operations issued in successive cycles are in flight together, each in its own row.
- R10: A table write and an issue of the same specifier in the same cycle use the old latency. The new value applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Latency table write strobe |
| cfg_op | input | $clog2(NUM_OPS) | Specifier whose latency is written |
| cfg_lat | input | CFG_W | Raw latency value (clamped on write) |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | Issue can be accepted this cycle |
| iss_wide | input | 1 | 1: four sources, 0: two sources |
| iss_op | input | $clog2(NUM_OPS) | Operation specifier |
| iss_src_a | input | DATA_W | Source value a |
| iss_src_b | input | DATA_W | Source value b |
| iss_src_c | input | DATA_W | Source value c (wide form only) |
| iss_src_d | input | DATA_W | Source value d (wide form only) |
| iss_dst0 | input | REG_W | Destination index of result 0 |
| iss_dst1 | input | REG_W | Destination index of result 1 |
| row_en | output | NUM_ROWS | Per-row execute enables |
| wb_valid | output | 1 | Write-back strobe |
| wb_dst0 | output | REG_W | Destination index of result 0 |
| wb_dst1 | output | REG_W | Destination index of result 1 |
| wb_data0 | output | DATA_W | Result 0 |
| wb_data1 | output | DATA_W | Result 1 |

## Verification
The assertions check on every cycle that:
- an accepted issue lands in the first row;
- an operation that does not retire moves to the next row;
- the last row always retires and never more than one row retires at a time;
- stored latencies stay in range;
- the issue port refuses only while work is in flight.

Only the bench scenarios can show that:
- the data values and destination indices come out correctly;
- the enables and write-back arrive at the exact cycles a given latency implies;
- clamped and same-cycle table writes take effect when required;
- the ready decision for a mix of latencies keeps results in order.

// File: rtl/rowpipe_pkg.sv
package rowpipe_pkg;

    // Issue form: how many source operands an operation carries
    typedef enum logic {
        FORM_NARROW = 1'b0,
        FORM_WIDE   = 1'b1
    } issue_form_e;

endpackage

// File: rtl/rowpipe_lat_table.sv
module rowpipe_lat_table #(
    parameter int NUM_OPS  = 16,
    parameter int NUM_ROWS = 8,
    parameter int CFG_W    = 8,
    parameter int OP_W     = $clog2(NUM_OPS),
    parameter int LAT_W    = $clog2(NUM_ROWS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OP_W-1:0]  wr_op,
    input  logic [CFG_W-1:0] wr_lat,
    input  logic [OP_W-1:0]  rd_op,
    output logic [LAT_W-1:0] rd_lat
);

    typedef struct packed {
        logic [NUM_OPS-1:0][LAT_W-1:0] lat;
    } tbl_t;

    tbl_t s_d, s_q;
    logic [LAT_W-1:0] clamped;

    always_comb begin
        s_d = s_q;
        if (wr_lat == '0)
            clamped = LAT_W'(1);
        else if (wr_lat > CFG_W'(NUM_ROWS))
            clamped = LAT_W'(NUM_ROWS);
        else
            clamped = wr_lat[LAT_W-1:0];
        if (wr_en)
            s_d.lat[wr_op] = clamped;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_OPS; i++)
                s_q.lat[i] <= LAT_W'(1);
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_lat = s_q.lat[rd_op];

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_chk
        // R2
        lat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (s_q.lat[g] != '0) && (s_q.lat[g] <= LAT_W'(NUM_ROWS)));
    end

endmodule

// File: rtl/rowpipe_order_gate.sv
module rowpipe_order_gate #(
    parameter int NUM_ROWS = 8,
    parameter int LAT_W    = $clog2(NUM_ROWS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [LAT_W-1:0] req_lat,
    output logic             ready,
    output logic             fire
);

    // tail: cycles from now until the write-back of the youngest accepted op
    typedef struct packed {
        logic [LAT_W-1:0] tail;
    } gate_t;

    gate_t s_d, s_q;

    always_comb begin
        ready = (req_lat >= s_q.tail);
        fire  = req && ready;
        s_d   = s_q;
        if (fire)
            s_d.tail = req_lat;
        else if (s_q.tail != '0)
            s_d.tail = s_q.tail - LAT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R8
    tail_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.tail <= LAT_W'(NUM_ROWS));

    // R8
    tail_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (s_q.tail != '0));

endmodule

// File: rtl/rowpipe_row_array.sv
module rowpipe_row_array #(
    parameter int NUM_ROWS = 8,
    parameter int DATA_W   = 32,
    parameter int REG_W    = 5,
    parameter int LAT_W    = $clog2(NUM_ROWS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [LAT_W-1:0]    load_lat,
    input  logic [REG_W-1:0]    load_dst0,
    input  logic [REG_W-1:0]    load_dst1,
    input  logic [DATA_W-1:0]   load_acc,
    input  logic [DATA_W-1:0]   load_aux,
    output logic [NUM_ROWS-1:0] row_en,
    output logic                wb_valid,
    output logic [REG_W-1:0]    wb_dst0,
    output logic [REG_W-1:0]    wb_dst1,
    output logic [DATA_W-1:0]   wb_data0,
    output logic [DATA_W-1:0]   wb_data1
);

    typedef struct packed {
        logic              vld;
        logic [LAT_W-1:0]  lat;
        logic [REG_W-1:0]  dst0;
        logic [REG_W-1:0]  dst1;
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] aux;
    } row_t;

    typedef struct packed {
        row_t [NUM_ROWS-1:0] row;
        logic              wb_vld;
        logic [REG_W-1:0]  wb_dst0;
        logic [REG_W-1:0]  wb_dst1;
        logic [DATA_W-1:0] wb_d0;
        logic [DATA_W-1:0] wb_d1;
    } pipe_t;

    pipe_t s_d, s_q;
    logic [NUM_ROWS-1:0] retire;
    logic [NUM_ROWS-1:0] row_vld;

    always_comb begin
        for (int i = 0; i < NUM_ROWS; i++) begin
            row_vld[i] = s_q.row[i].vld;
            retire[i]  = s_q.row[i].vld && (s_q.row[i].lat == LAT_W'(i + 1));
        end
    end

    always_comb begin
        s_d        = s_q;
        s_d.wb_vld = 1'b0;
        s_d.row    = '0;
        // an evaluating row adds one to the first lane and hands it on
        for (int j = 1; j < NUM_ROWS; j++) begin
            if (row_vld[j-1] && !retire[j-1]) begin
                s_d.row[j]     = s_q.row[j-1];
                s_d.row[j].acc = s_q.row[j-1].acc + DATA_W'(1);
            end
        end
        for (int i = 0; i < NUM_ROWS; i++) begin
            if (retire[i]) begin
                s_d.wb_vld  = 1'b1;
                s_d.wb_dst0 = s_q.row[i].dst0;
                s_d.wb_dst1 = s_q.row[i].dst1;
                s_d.wb_d0   = s_q.row[i].acc + DATA_W'(1);
                s_d.wb_d1   = s_q.row[i].aux;
            end
        end
        if (load) begin
            s_d.row[0].vld  = 1'b1;
            s_d.row[0].lat  = load_lat;
            s_d.row[0].dst0 = load_dst0;
            s_d.row[0].dst1 = load_dst1;
            s_d.row[0].acc  = load_acc;
            s_d.row[0].aux  = load_aux;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign row_en   = row_vld;
    assign wb_valid = s_q.wb_vld;
    assign wb_dst0  = s_q.wb_dst0;
    assign wb_dst1  = s_q.wb_dst1;
    assign wb_data0 = s_q.wb_d0;
    assign wb_data1 = s_q.wb_d1;

    // R8
    single_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(retire));

    // R4
    last_row_retires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_vld[NUM_ROWS-1] |-> retire[NUM_ROWS-1]);

    for (genvar g = 0; g < NUM_ROWS - 1; g++) begin : g_adv
        // R3
        row_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (row_vld[g] && !retire[g]) |=> row_vld[g+1]);
    end

endmodule

// File: rtl/rowpipe_exec_ctrl.sv
module rowpipe_exec_ctrl
    import rowpipe_pkg::*;
#(
    parameter int NUM_ROWS = 8,
    parameter int NUM_OPS  = 16,
    parameter int DATA_W   = 32,
    parameter int REG_W    = 5,
    parameter int CFG_W    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [$clog2(NUM_OPS)-1:0] cfg_op,
    input  logic [CFG_W-1:0]           cfg_lat,
    input  logic                       iss_valid,
    output logic                       iss_ready,
    input  logic                       iss_wide,
    input  logic [$clog2(NUM_OPS)-1:0] iss_op,
    input  logic [DATA_W-1:0]          iss_src_a,
    input  logic [DATA_W-1:0]          iss_src_b,
    input  logic [DATA_W-1:0]          iss_src_c,
    input  logic [DATA_W-1:0]          iss_src_d,
    input  logic [REG_W-1:0]           iss_dst0,
    input  logic [REG_W-1:0]           iss_dst1,
    output logic [NUM_ROWS-1:0]        row_en,
    output logic                       wb_valid,
    output logic [REG_W-1:0]           wb_dst0,
    output logic [REG_W-1:0]           wb_dst1,
    output logic [DATA_W-1:0]          wb_data0,
    output logic [DATA_W-1:0]          wb_data1
);

    localparam int OP_W  = $clog2(NUM_OPS);
    localparam int LAT_W = $clog2(NUM_ROWS + 1);

    logic [LAT_W-1:0]  op_lat;
    logic              fire;
    logic [DATA_W-1:0] base_acc;
    logic [DATA_W-1:0] base_aux;
    issue_form_e       form;

    always_comb begin
        form = issue_form_e'(iss_wide);
        if (form == FORM_WIDE) begin
            base_acc = iss_src_a + iss_src_b + iss_src_c + iss_src_d;
            base_aux = iss_src_a ^ iss_src_b ^ iss_src_c ^ iss_src_d;
        end else begin
            base_acc = iss_src_a + iss_src_b;
            base_aux = iss_src_a ^ iss_src_b;
        end
    end

    rowpipe_lat_table #(
        .NUM_OPS (NUM_OPS),
        .NUM_ROWS(NUM_ROWS),
        .CFG_W   (CFG_W),
        .OP_W    (OP_W),
        .LAT_W   (LAT_W)
    ) u_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_we),
        .wr_op (cfg_op),
        .wr_lat(cfg_lat),
        .rd_op (iss_op),
        .rd_lat(op_lat)
    );

    rowpipe_order_gate #(
        .NUM_ROWS(NUM_ROWS),
        .LAT_W   (LAT_W)
    ) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (iss_valid),
        .req_lat(op_lat),
        .ready  (iss_ready),
        .fire   (fire)
    );

    rowpipe_row_array #(
        .NUM_ROWS(NUM_ROWS),
        .DATA_W  (DATA_W),
        .REG_W   (REG_W),
        .LAT_W   (LAT_W)
    ) u_rows (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (fire),
        .load_lat (op_lat),
        .load_dst0(iss_dst0),
        .load_dst1(iss_dst1),
        .load_acc (base_acc),
        .load_aux (base_aux),
        .row_en   (row_en),
        .wb_valid (wb_valid),
        .wb_dst0  (wb_dst0),
        .wb_dst1  (wb_dst1),
        .wb_data0 (wb_data0),
        .wb_data1 (wb_data1)
    );

    // R3
    issue_enters_row0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready) |=> row_en[0]);

    // R8
    stall_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_ready |-> (|row_en));

    // R4
    wb_from_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(|row_en));

endmodule

// File: tb/rowpipe_exec_ctrl_tb.sv
`timescale 1ns/1ps
module rowpipe_exec_ctrl_tb;

    localparam int ROWS = 8;
    localparam int OPS  = 16;
    localparam int DW   = 32;
    localparam int RW   = 5;
    localparam int CW   = 8;
    localparam int OW   = $clog2(OPS);
    localparam int MAXQ = 8192;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic            rst_n;
    logic            cfg_we;
    logic [OW-1:0]   cfg_op;
    logic [CW-1:0]   cfg_lat;
    logic            iss_valid, iss_ready, iss_wide;
    logic [OW-1:0]   iss_op;
    logic [DW-1:0]   iss_src_a, iss_src_b, iss_src_c, iss_src_d;
    logic [RW-1:0]   iss_dst0, iss_dst1;
    logic [ROWS-1:0] row_en;
    logic            wb_valid;
    logic [RW-1:0]   wb_dst0, wb_dst1;
    logic [DW-1:0]   wb_data0, wb_data1;

    rowpipe_exec_ctrl #(
        .NUM_ROWS(ROWS), .NUM_OPS(OPS), .DATA_W(DW), .REG_W(RW), .CFG_W(CW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_lat(cfg_lat),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_wide(iss_wide),
        .iss_op(iss_op),
        .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
        .iss_src_c(iss_src_c), .iss_src_d(iss_src_d),
        .iss_dst0(iss_dst0), .iss_dst1(iss_dst1),
        .row_en(row_en), .wb_valid(wb_valid),
        .wb_dst0(wb_dst0), .wb_dst1(wb_dst1),
        .wb_data0(wb_data0), .wb_data1(wb_data1)
    );

    int checks = 0;
    int errors = 0;
    string ctx = "";

    int tbl [OPS];
    int q_c [MAXQ];
    int q_l [MAXQ];
    bit q_w [MAXQ];
    logic [DW-1:0] q_d0 [MAXQ];
    logic [DW-1:0] q_d1 [MAXQ];
    logic [RW-1:0] q_t0 [MAXQ];
    logic [RW-1:0] q_t1 [MAXQ];
    int qn = 0, qh = 0, last_wb = -1, cyc = 0, multi = 0;

    function automatic int clamp_lat(int raw);
        if (raw < 1) return 1;
        if (raw > ROWS) return ROWS;
        return raw;
    endfunction

    function automatic logic [DW-1:0] exp_d0(bit w, logic [DW-1:0] a, logic [DW-1:0] b,
                                             logic [DW-1:0] c, logic [DW-1:0] d, int l);
        if (w) return a + b + c + d + DW'(l);
        return a + b + DW'(l);
    endfunction

    function automatic logic [DW-1:0] exp_d1(bit w, logic [DW-1:0] a, logic [DW-1:0] b,
                                             logic [DW-1:0] c, logic [DW-1:0] d);
        if (w) return a ^ b ^ c ^ d;
        return a ^ b;
    endfunction

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s (%s): got %0h exp %0h", tag, ctx, got, exp);
        end
    endtask

    task automatic step(bit v, bit w, int op, logic [DW-1:0] a, logic [DW-1:0] b,
                        logic [DW-1:0] c, logic [DW-1:0] d, int t0, int t1,
                        bit we, int cop, int clat);
        logic [ROWS-1:0] er;
        bit ewb;
        int wi;
        int lat;
        bit erdy;
        @(negedge clk);
        iss_valid = v; iss_wide = w; iss_op = OW'(op);
        iss_src_a = a; iss_src_b = b; iss_src_c = c; iss_src_d = d;
        iss_dst0 = RW'(t0); iss_dst1 = RW'(t1);
        cfg_we = we; cfg_op = OW'(cop); cfg_lat = CW'(clat);
        #1;
        er = '0; ewb = 0; wi = -1;
        for (int k = qh; k < qn; k++) begin
            int s;
            s = cyc - q_c[k] - 1;
            if (s >= 0 && s < q_l[k]) er[s] = 1'b1;
            if (cyc == q_c[k] + q_l[k] + 1) begin ewb = 1; wi = k; end
        end
        chk("R3/R4 row enables", 64'(row_en), 64'(er));
        chk("R4 write-back strobe", 64'(wb_valid), 64'(ewb));
        if (ewb && wb_valid) begin
            if (q_w[wi]) begin
                chk("R6 wide data0", 64'(wb_data0), 64'(q_d0[wi]));
                chk("R6 wide data1", 64'(wb_data1), 64'(q_d1[wi]));
            end else begin
                chk("R5 narrow data0", 64'(wb_data0), 64'(q_d0[wi]));
                chk("R5 narrow data1", 64'(wb_data1), 64'(q_d1[wi]));
            end
            chk("R7 dst0", 64'(wb_dst0), 64'(q_t0[wi]));
            chk("R7 dst1", 64'(wb_dst1), 64'(q_t1[wi]));
            chk("R8 issue order", 64'(wi), 64'(qh));
            qh = wi + 1;
        end
        if ($countones(er) > 1) multi++;
        lat  = tbl[op];
        erdy = (cyc + lat + 1 > last_wb);
        chk("R8 ready", 64'(iss_ready), 64'(erdy));
        if (v && erdy) begin
            q_c[qn] = cyc; q_l[qn] = lat; q_w[qn] = w;
            q_d0[qn] = exp_d0(w, a, b, c, d, lat);
            q_d1[qn] = exp_d1(w, a, b, c, d);
            q_t0[qn] = RW'(t0); q_t1[qn] = RW'(t1);
            last_wb = cyc + lat + 1;
            qn++;
        end
        if (we) tbl[cop] = clamp_lat(clat);
        @(posedge clk);
        cyc++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        summary();
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd24681);
        for (int i = 0; i < OPS; i++) tbl[i] = 1;
        rst_n = 1'b0; cfg_we = 0; cfg_op = 0; cfg_lat = 0;
        iss_valid = 0; iss_wide = 0; iss_op = 0;
        iss_src_a = 0; iss_src_b = 0; iss_src_c = 0; iss_src_d = 0;
        iss_dst0 = 0; iss_dst1 = 0;
        repeat (3) @(negedge clk);
        ctx = "R1 reset";
        chk("R1 row_en", 64'(row_en), 64'd0);
        chk("R1 wb_valid", 64'(wb_valid), 64'd0);
        chk("R1 iss_ready", 64'(iss_ready), 64'd1);
        rst_n = 1'b1;
        idle(2);

        ctx = "R2 reset latency";
        step(1, 0, 3, 32'h10, 32'h20, 32'h5, 32'h6, 4, 9, 0, 0, 0);
        idle(4);

        ctx = "R2 clamp";
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 5, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 6, 200);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 7, 4);
        step(1, 0, 5, 32'hFFFF_FFFF, 32'h1, 0, 0, 1, 2, 0, 0, 0);
        idle(3);
        step(1, 1, 6, 32'h1, 32'h2, 32'h3, 32'h4, 30, 31, 0, 0, 0);
        idle(10);
        step(1, 1, 7, 32'hA5A5_0000, 32'h0000_5A5A, 32'hFFFF_FFFF, 32'h8000_0000, 7, 8, 0, 0, 0);
        idle(6);

        ctx = "R10 same-cycle write";
        step(1, 0, 8, 32'h100, 32'h200, 0, 0, 11, 12, 1, 8, 6);
        idle(3);
        step(1, 0, 8, 32'h300, 32'h400, 0, 0, 13, 14, 0, 0, 0);
        idle(9);

        ctx = "R8 stall";
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 8);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 2, 1);
        step(1, 0, 1, 32'h11, 32'h22, 0, 0, 1, 1, 0, 0, 0);
        for (int i = 0; i < 10; i++)
            step(1, 1, 2, 32'h1 + i, 32'h2, 32'h3, 32'h4, 2, 3, 0, 0, 0);
        idle(10);

        ctx = "R9 back-to-back";
        for (int i = 0; i < 6; i++)
            step(1, i % 2, 7, 32'h1000 * i, 32'h7, 32'h9, 32'h1, i, 31 - i, 0, 0, 0);
        idle(10);

        ctx = "random";
        for (int i = 0; i < 4000; i++) begin
            bit we, v, w;
            we = ($urandom() % 16) == 0;
            v  = ($urandom() % 10) < 6;
            w  = $urandom() % 2;
            step(v, w, $urandom() % OPS, $urandom(), $urandom(), $urandom(), $urandom(),
                 $urandom() % 32, $urandom() % 32, we, $urandom() % OPS, $urandom() % 12);
        end
        idle(12);

        ctx = "R9 summary";
        chk("R9 concurrent rows seen", 64'(multi > 0), 64'd1);
        summary();
        $finish;
    end

endmodule